// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block runs when the translation cache misses. It takes the linear address that missed, the kind of access (read or write), the privilege mode (user or supervisor) and the frame number of the page directory. It then walks a two-level page table in memory through a 32-bit port. The port carries one request at a time and uses a request/acknowledge handshake.

The walk first fetches the directory entry and then the page-table entry. If the accessed bit of the directory entry is clear, the walker writes the entry back with that bit set. It does the same for the accessed bit of the page-table entry, and for its dirty bit on a write. A write-back is issued only when one of those bits changes. The walk ends in one of two ways. Either the walker offers a refill entry to the translation cache, or it raises a page fault. On a fault it records the faulting linear address and whether the cause was a missing page or a protection violation.

Top module: `pageWalker`

## Requirements
- R1: The first memory access of a walk is a read at `{dirFrame, 12'h000} + 4 * walkLinAddr[31:22]`.
- R2: If bit 0 (present) of the directory entry is 0, the walk ends in a fault with `faultNotPresent` = 1, and no further memory access is made.
- R3: If the directory entry is present and its bit 5 (accessed) is 0, the next access writes the directory entry, with bit 5 set, back to the same address. If bit 5 is already 1, no write is made.
- R4: After the directory stage, the walker reads at `{pde[31:12], 12'h000} + 4 * walkLinAddr[21:12]`.
- R5: If bit 0 of the page-table entry is 0, the walk ends in a fault with `faultNotPresent` = 1.
- R6: For a present page that passes the protection check, the new page-table entry is the old one with bit 5 set, and also with bit 6 (dirty) set on a write. It is written back to the same address only if it differs from the old value.
- R7: A user access faults (with `faultNotPresent` = 0) unless bit 2 (user) is set in both entries. A user write also faults unless bit 1 (writable) is set in both entries. Supervisor accesses ignore bits 1 and 2. A protection fault makes no page-table write.
- R8: On a fault, `faultValid` pulses for one cycle and `faultAddr` holds the full faulting linear address. `faultAddr` keeps that value until the next fault.
- R9: On success, `refillValid` pulses for one cycle with these values: tag = linear bits 31:12, frame = pte[31:12], writable = AND of bit 1 of both entries, user = AND of bit 2 of both entries, dirty = the final bit 6. `refillValid` and `faultValid` are never high together.
- R10: `walkReq` is ignored while `walkBusy` is high. A request raised during a walk neither changes the walk nor starts a new one.
- R11: `memReq` stays high, with `memAddr`, `memWe` and `memWdata` stable, until the cycle in which `memAck` is sampled high. `memReq` is low while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkReq | input | 1 | Start a walk (taken when idle) |
| walkLinAddr | input | 32 | Linear address that missed |
| walkWrite | input | 1 | 1 = write access |
| walkUser | input | 1 | 1 = user mode |
| dirFrame | input | 20 | Frame number of the page directory |
| walkBusy | output | 1 | Walk in progress |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write request |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Request completes this cycle |
| refillValid | output | 1 | Refill entry valid |
| refillTag | output | 20 | Linear page number |
| refillFrame | output | 20 | Physical frame number |
| refillWritable | output | 1 | Combined writable permission |
| refillUser | output | 1 | Combined user permission |
| refillDirty | output | 1 | Dirty state after the walk |
| faultValid | output | 1 | Page fault pulse |
| faultNotPresent | output | 1 | 1 = missing entry, 0 = protection fault |
| faultAddr | output | 32 | Last faulting linear address |

## Verification
The hardest cases to reach are a new walk request that arrives in the middle of a walk, and memory acknowledges that come late while the walker must keep its request steady. The bench raises `walkReq` with a different address while an acknowledge is pending. It also stretches each acknowledge by a random 0 to 2 cycles, and checks at every waiting cycle that the request is held. Random entry bits, biased toward present, cover the write-back and protection combinations. Directed walks fix the rarer paths: a missing directory entry, a supervisor write to a read-only page, and a user write on a page whose writable bit is set at only one level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFS_W   = 12;
  localparam int IDX_W   = 10;
  localparam int FRAME_W = ADDR_W - OFS_W;

  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_UPD_DIR, ST_RD_TBL, ST_UPD_TBL, ST_DONE, ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic captureReq;
    logic loadPde;
    logic loadPte;
    logic setFault;
    logic faultNp;
    logic selTable;
  } ctrlStrobes_t;
endpackage

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]    walkLinAddr,
  input  logic                 walkWrite,
  input  logic                 walkUser,
  input  logic [FRAME_W-1:0]   dirFrame,
  input  logic [ADDR_W-1:0]    memRdata,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [ADDR_W-1:0]    memWdata,
  output logic                 rdPresent,
  output logic                 rdAccessed,
  output logic                 protViol,
  output logic                 pteNeedsUpd,
  output logic [FRAME_W-1:0]   refillTag,
  output logic [FRAME_W-1:0]   refillFrame,
  output logic                 refillWritable,
  output logic                 refillUser,
  output logic                 refillDirty,
  output logic [ADDR_W-1:0]    faultAddr,
  output logic                 faultNotPresent
);
  localparam logic [ADDR_W-1:0] ACC_MASK = ADDR_W'(1) << BIT_A;
  localparam logic [ADDR_W-1:0] DRT_MASK = ADDR_W'(1) << BIT_D;

  logic [ADDR_W-1:0]  linReg;
  logic               isWrite;
  logic               isUser;
  logic [FRAME_W-1:0] dirReg;
  logic [ADDR_W-1:0]  pdeReg;
  logic [ADDR_W-1:0]  pteReg;
  logic [ADDR_W-1:0]  faultAddrReg;
  logic               faultNpReg;

  logic [ADDR_W-1:0] pdeAddr, pteAddr, pdeNew, pteNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linReg       <= '0;
      isWrite      <= 1'b0;
      isUser       <= 1'b0;
      dirReg       <= '0;
      pdeReg       <= '0;
      pteReg       <= '0;
      faultAddrReg <= '0;
      faultNpReg   <= 1'b0;
    end else begin
      if (strobes.captureReq) begin
        linReg  <= walkLinAddr;
        isWrite <= walkWrite;
        isUser  <= walkUser;
        dirReg  <= dirFrame;
      end
      if (strobes.loadPde) pdeReg <= memRdata;
      if (strobes.loadPte) pteReg <= memRdata;
      if (strobes.setFault) begin
        faultAddrReg <= linReg;
        faultNpReg   <= strobes.faultNp;
      end
    end
  end

  always_comb begin
    pdeAddr = {dirReg, {OFS_W{1'b0}}}
            + {{(ADDR_W-IDX_W-2){1'b0}}, linReg[ADDR_W-1 -: IDX_W], 2'b00};
    pteAddr = {pdeReg[ADDR_W-1:OFS_W], {OFS_W{1'b0}}}
            + {{(ADDR_W-IDX_W-2){1'b0}}, linReg[OFS_W+IDX_W-1:OFS_W], 2'b00};
    pdeNew  = pdeReg | ACC_MASK;
    pteNew  = pteReg | ACC_MASK | (isWrite ? DRT_MASK : '0);
    memAddr  = strobes.selTable ? pteAddr : pdeAddr;
    memWdata = strobes.selTable ? pteNew  : pdeNew;
  end

  always_comb begin
    rdPresent   = memRdata[BIT_P];
    rdAccessed  = memRdata[BIT_A];
    protViol    = isUser && (!(pdeReg[BIT_US] && memRdata[BIT_US])
                  || (isWrite && !(pdeReg[BIT_RW] && memRdata[BIT_RW])));
    pteNeedsUpd = !memRdata[BIT_A] || (isWrite && !memRdata[BIT_D]);
  end

  assign refillTag       = linReg[ADDR_W-1:OFS_W];
  assign refillFrame     = pteReg[ADDR_W-1:OFS_W];
  assign refillWritable  = pdeReg[BIT_RW] & pteReg[BIT_RW];
  assign refillUser      = pdeReg[BIT_US] & pteReg[BIT_US];
  assign refillDirty     = pteNew[BIT_D];
  assign faultAddr       = faultAddrReg;
  assign faultNotPresent = faultNpReg;

  AST_FAULT_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.setFault |=> $stable(faultAddrReg)); // R8
endmodule

// File: rtl/ptwControl.sv
module ptwControl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         walkReq,
  input  logic         memAck,
  input  logic         rdPresent,
  input  logic         rdAccessed,
  input  logic         protViol,
  input  logic         pteNeedsUpd,
  output ctrlStrobes_t strobes,
  output logic         memReq,
  output logic         memWe,
  output logic         walkBusy,
  output logic         refillValid,
  output logic         faultValid
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobes     = '0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    refillValid = 1'b0;
    faultValid  = 1'b0;
    unique case (state)
      ST_IDLE: if (walkReq) begin
        strobes.captureReq = 1'b1;
        nextState = ST_RD_DIR;
      end
      ST_RD_DIR: begin
        memReq = 1'b1;
        if (memAck) begin
          strobes.loadPde = 1'b1;
          if (!rdPresent) begin
            strobes.setFault = 1'b1;
            strobes.faultNp  = 1'b1;
            nextState = ST_FAULT;
          end else if (!rdAccessed) nextState = ST_UPD_DIR;
          else nextState = ST_RD_TBL;
        end
      end
      ST_UPD_DIR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nextState = ST_RD_TBL;
      end
      ST_RD_TBL: begin
        memReq = 1'b1;
        strobes.selTable = 1'b1;
        if (memAck) begin
          strobes.loadPte = 1'b1;
          if (!rdPresent) begin
            strobes.setFault = 1'b1;
            strobes.faultNp  = 1'b1;
            nextState = ST_FAULT;
          end else if (protViol) begin
            strobes.setFault = 1'b1;
            nextState = ST_FAULT;
          end else if (pteNeedsUpd) nextState = ST_UPD_TBL;
          else nextState = ST_DONE;
        end
      end
      ST_UPD_TBL: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobes.selTable = 1'b1;
        if (memAck) nextState = ST_DONE;
      end
      ST_DONE: begin
        refillValid = 1'b1;
        nextState = ST_IDLE;
      end
      ST_FAULT: begin
        faultValid = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign walkBusy = (state != ST_IDLE);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(refillValid && faultValid)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !walkBusy |-> !memReq); // R11
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    walkBusy && walkReq |-> !strobes.captureReq); // R10
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        walkReq,
  input  logic [31:0] walkLinAddr,
  input  logic        walkWrite,
  input  logic        walkUser,
  input  logic [19:0] dirFrame,
  output logic        walkBusy,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic        refillValid,
  output logic [19:0] refillTag,
  output logic [19:0] refillFrame,
  output logic        refillWritable,
  output logic        refillUser,
  output logic        refillDirty,
  output logic        faultValid,
  output logic        faultNotPresent,
  output logic [31:0] faultAddr
);
  ctrlStrobes_t strobes;
  logic rdPresent, rdAccessed, protViol, pteNeedsUpd;

  ptwControl uCtrl (
    .clk(clk), .rstN(rstN), .walkReq(walkReq), .memAck(memAck),
    .rdPresent(rdPresent), .rdAccessed(rdAccessed), .protViol(protViol),
    .pteNeedsUpd(pteNeedsUpd), .strobes(strobes), .memReq(memReq),
    .memWe(memWe), .walkBusy(walkBusy), .refillValid(refillValid),
    .faultValid(faultValid)
  );

  ptwDatapath uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .walkLinAddr(walkLinAddr),
    .walkWrite(walkWrite), .walkUser(walkUser), .dirFrame(dirFrame),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .rdPresent(rdPresent), .rdAccessed(rdAccessed), .protViol(protViol),
    .pteNeedsUpd(pteNeedsUpd), .refillTag(refillTag), .refillFrame(refillFrame),
    .refillWritable(refillWritable), .refillUser(refillUser),
    .refillDirty(refillDirty), .faultAddr(faultAddr),
    .faultNotPresent(faultNotPresent)
  );

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)
                          && $stable(memWdata)); // R11
  AST_WB_SETS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[BIT_A] && memWdata[BIT_P]); // R3
endmodule

// File: tb/sim_pageWalker.sv
module sim_pageWalker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        walkReq = 1'b0;
  logic [31:0] walkLinAddr = '0;
  logic        walkWrite = 1'b0;
  logic        walkUser = 1'b0;
  logic [19:0] dirFrame = '0;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        walkBusy, memReq, memWe, refillValid, refillWritable, refillUser;
  logic        refillDirty, faultValid, faultNotPresent;
  logic [31:0] memAddr, memWdata, faultAddr;
  logic [19:0] refillTag, refillFrame;

  int checks = 0;
  int fails = 0;
  logic [31:0] lastFault = '0;
  bit done = 0;

  always #2 clk = ~clk;

  pageWalker u0 (.*);

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runWalk(logic [31:0] lin, bit wr, bit usr, logic [19:0] base,
                         logic [31:0] pde, logic [31:0] pte, bit interfere);
    logic [31:0] eAddr[4], eData[4], gAddr[4], gData[4];
    bit eWe[4], gWe[4];
    int eN = 0, gN = 0, rdIdx = 0;
    bit eFault = 0, eNp = 0, gotRefill = 0, gotFault = 0;
    logic [31:0] pdeAddr, pteAddr, newPte;
    pdeAddr = {base, 12'h000} + {20'h0, lin[31:22], 2'b00};
    eAddr[eN] = pdeAddr; eWe[eN] = 0; eData[eN] = 'x; eN++;
    if (!pde[0]) begin eFault = 1; eNp = 1; end
    else begin
      if (!pde[5]) begin eAddr[eN] = pdeAddr; eWe[eN] = 1; eData[eN] = pde | 32'h20; eN++; end
      pteAddr = {pde[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00};
      eAddr[eN] = pteAddr; eWe[eN] = 0; eData[eN] = 'x; eN++;
      if (!pte[0]) begin eFault = 1; eNp = 1; end
      else if (usr && (!(pde[2] && pte[2]) || (wr && !(pde[1] && pte[1])))) eFault = 1;
      else begin
        newPte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (newPte != pte) begin eAddr[eN] = pteAddr; eWe[eN] = 1; eData[eN] = newPte; eN++; end
      end
    end
    walkLinAddr = lin; walkWrite = wr; walkUser = usr; dirFrame = base; walkReq = 1;
    @(negedge clk);
    walkReq = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (refillValid || faultValid) begin
        gotRefill = refillValid; gotFault = faultValid; break;
      end
      if (memReq) begin
        logic [31:0] a, d; bit w;
        a = memAddr; d = memWdata; w = memWe;
        for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
          if (interfere && gN == 1) begin
            walkReq = 1; walkLinAddr = ~lin; walkWrite = ~wr; walkUser = ~usr;
          end
          @(negedge clk);
          check(memReq && memAddr == a && memWe == w && (!w || memWdata == d),
                "R11 hold", {memAddr, memWdata}, {a, d});
        end
        if (gN < 4) begin gAddr[gN] = a; gWe[gN] = w; gData[gN] = d; end
        gN++;
        if (!w) begin memRdata = (rdIdx == 0) ? pde : pte; rdIdx++; end
        if (interfere && gN == 2) begin walkReq = 1; walkLinAddr = ~lin; end
        memAck = 1;
        @(negedge clk);
        memAck = 0; walkReq = 0; memRdata = '0;
        walkLinAddr = lin; walkWrite = wr; walkUser = usr;
      end else @(negedge clk);
    end
    check(gN == eN, "R1/R3/R4/R6 access count", 64'(gN), 64'(eN));
    for (int i = 0; i < 4; i++) begin
      if (i < eN && i < gN) begin
        check(gAddr[i] == eAddr[i] && gWe[i] == eWe[i],
              (i == 0) ? "R1 dir addr" : (eWe[i] ? "R3/R6 write-back addr" : "R4 table addr"),
              {31'b0, gWe[i], gAddr[i]}, {31'b0, eWe[i], eAddr[i]});
        if (eWe[i]) check(gData[i] == eData[i], "R3/R6 write-back data",
                          64'(gData[i]), 64'(eData[i]));
      end
    end
    check(gotFault == eFault && gotRefill == !eFault, "R2/R5/R7 outcome",
          {gotFault, gotRefill}, {eFault, !eFault});
    if (gotFault && eFault) begin
      check(faultAddr == lin, "R8 fault address", 64'(faultAddr), 64'(lin));
      check(faultNotPresent == eNp, eNp ? "R2/R5 not-present code" : "R7 protection code",
            64'(faultNotPresent), 64'(eNp));
      lastFault = lin;
    end
    if (gotRefill && !eFault) begin
      logic [63:0] got, exp;
      got = {refillTag, refillFrame, refillWritable, refillUser, refillDirty};
      exp = {lin[31:12], pte[31:12], pde[1] & pte[1], pde[2] & pte[2], pte[6] | wr};
      check(got == exp, "R9 refill entry", got, exp);
      check(faultAddr == lastFault, "R8 fault address retained",
            64'(faultAddr), 64'(lastFault));
    end
    @(negedge clk);
    check(!walkBusy && !memReq, "R10 idle after walk", {walkBusy, memReq}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!walkBusy && !memReq && !refillValid && !faultValid && faultAddr == 0,
          "R11 reset state", {walkBusy, memReq, refillValid, faultValid, faultAddr}, 64'h0);
    // R2: directory not present
    runWalk(32'hABCD_E123, 0, 0, 20'h12345, 32'h0000_0006, 32'h0, 0);
    // R5: table entry not present, directory accessed already set
    runWalk(32'h0040_3000, 1, 0, 20'h00100, 32'h0020_0027, 32'h0000_0066, 0);
    // R7: user read on supervisor page
    runWalk(32'h8000_1000, 0, 1, 20'h00200, 32'h0030_0007, 32'h0040_0023, 0);
    // R7: user write, writable only at directory level
    runWalk(32'h8000_2004, 1, 1, 20'h00200, 32'h0030_0027, 32'h0040_0025, 0);
    // R7: supervisor write to read-only page succeeds, dirty set (R6)
    runWalk(32'h1234_5678, 1, 0, 20'h00300, 32'h0050_0001, 32'h0060_0001, 0);
    // R6: read of already accessed page, no table write-back
    runWalk(32'h2222_2222, 0, 1, 20'h00400, 32'h0070_0027, 32'h0080_0027, 0);
    // R6: write of accessed but clean page
    runWalk(32'h3333_3333, 1, 1, 20'h00500, 32'h0090_0007, 32'h00A0_0027, 0);
    // R10: new request raised mid-walk is ignored
    runWalk(32'h4444_5555, 1, 0, 20'h00600, 32'h00B0_0003, 32'h00C0_0003, 1);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] pde, pte;
      pde = $urandom(); pte = $urandom();
      pde[0] = ($urandom_range(0, 9) != 0);
      pte[0] = ($urandom_range(0, 9) != 0);
      runWalk($urandom(), 1'($urandom()), 1'($urandom()), 20'($urandom()),
              pde, pte, ($urandom_range(0, 7) == 0));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule